// File: doc/BRIEF.md
# Vector Rounding Shift-Narrow Unit

The unit takes a 256-bit vector of wide elements and a second 256-bit vector of per-element shift amounts. Each wide element is shifted right by its own amount with round-half-up, then cut to half its width. A mode bit picks a zero-filling (logical) or sign-filling (arithmetic) shift. A two-bit size code picks the narrowing step: 16 to 8, 32 to 16, or 64 to 32 bits.

The vector is handled as two separate 128-bit lanes, and no data moves between them. In each lane the narrowed results are packed from the bottom into the lower 64 bits, and the upper 64 bits are written as zero.

The result is captured in an output register on each clock edge where the input strobe is high. The output valid goes high in the cycle that follows. The unit does not saturate, decode, or touch a register file.

Top module: `rshn_unit`

## Requirements
- R1: The two 128-bit lanes are independent: result bits [255:128] depend only on bits [255:128] of both operands, and result bits [127:0] depend only on bits [127:0] of both operands.
- R2: In each lane, source element j of width W (at lane bits [j*W +: W]) produces result element j of width W/2 at lane bits [j*W/2 +: W/2].
- R3: Bits [127:64] and [255:192] of the result are always zero.
- R4: The shift amount for element j is element j of the shift vector, read as unsigned and taken modulo W. This means only its low log2(W) bits count.
- R5: With `arith`=0 the source element is unsigned and shifted with zero fill. With `arith`=1 it is two's complement and shifted with sign fill.
- R6: For a nonzero shift s, the bit at position s-1 of the source is added to the shifted value. With s=0 nothing is added. The sum is truncated to W/2 bits with no saturation.
- R7: Size code `size`: 0 selects 16 to 8, 1 selects 32 to 16, and 2 selects 64 to 32. Code 3 yields an all-zero result.
- R8: When `in_valid` is high at a rising edge, the result of the inputs at that edge appears on `result`, and `out_valid` is high until the next edge. When `in_valid` is low, `out_valid` goes low and `result` holds its value.
- R9: Synchronous active-high reset clears `result` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operands |
| arith | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| size | input | 2 | Narrowing size code |
| src | input | 256 | Wide source elements |
| shv | input | 256 | Per-element shift amounts |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 256 | Narrowed, rounded result |

## Verification
The hardest cases to reach are those where rounding carries across the whole half-width field and the truncated sum wraps to zero. Such a case needs an all-ones or sign-boundary source together with a shift whose discarded top bit is one. Directed vectors build these cases on purpose, for example all-ones 64-bit elements shifted by one. They also place shift elements whose upper bits are set, so the modulo reduction is exercised. A table of size, mode and shift-pattern rows, with random data, then covers shifts of 0 and W-1 in every size. Each row is compared with a reference model in the bench that rounds by adding 2^(s-1) in wider arithmetic.

// File: rtl/rshn_pkg.sv
package rshn_pkg;
  localparam int unsigned NSIZE = 3;
  typedef enum logic [1:0] {
    SZ_16_8  = 2'd0,
    SZ_32_16 = 2'd1,
    SZ_64_32 = 2'd2,
    SZ_NONE  = 2'd3
  } size_e;
endpackage

// File: rtl/rshn_elem.sv
module rshn_elem #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   amt_raw,
  input  logic           arith,
  output logic [W/2-1:0] res
);
  localparam int unsigned SW = $clog2(W);
  localparam int unsigned HW = W / 2;

  logic [SW-1:0] amt;
  logic [W-1:0]  shifted;
  logic          rbit;

  always_comb begin
    amt = SW'(amt_raw);
    if (arith) shifted = W'($signed(src) >>> amt);
    else       shifted = src >> amt;
    rbit = (amt != '0) ? src[amt - SW'(1)] : 1'b0;
    res  = HW'(shifted + W'(rbit));
  end

  // R6: a zero shift passes the low half through untouched
  always_comb begin
    if (amt == '0) begin
      a_zero_shift_r6: assert (res == src[HW-1:0]);
    end
  end
endmodule

// File: rtl/rshn_lane.sv
module rshn_lane
  import rshn_pkg::*;
#(
  parameter int unsigned LANE_W = 128
) (
  input  logic [LANE_W-1:0] src,
  input  logic [LANE_W-1:0] shv,
  input  logic              arith,
  input  logic [1:0]        size,
  output logic [LANE_W-1:0] res
);
  localparam int unsigned HALF = LANE_W / 2;

  logic [NSIZE-1:0][HALF-1:0] nar;

  for (genvar s = 0; s < NSIZE; s++) begin : g_sz
    localparam int unsigned W = 16 << s;
    localparam int unsigned N = LANE_W / W;
    logic [HALF-1:0] pk;
    for (genvar j = 0; j < N; j++) begin : g_el
      rshn_elem #(.W(W)) u_elem (
        .src    (src[j*W +: W]),
        .amt_raw(shv[j*W +: W]),
        .arith  (arith),
        .res    (pk[j*(W/2) +: W/2])
      );
    end
    assign nar[s] = pk;
  end

  always_comb begin
    unique case (size_e'(size))
      SZ_16_8:  res = {{HALF{1'b0}}, nar[0]};
      SZ_32_16: res = {{HALF{1'b0}}, nar[1]};
      SZ_64_32: res = {{HALF{1'b0}}, nar[2]};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/rshn_unit.sv
module rshn_unit #(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             arith,
  input  logic [1:0]       size,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] shv,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int unsigned NLANE = VEC_W / LANE_W;
  localparam int unsigned HALF  = LANE_W / 2;

  logic [VEC_W-1:0] nxt;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    rshn_lane #(.LANE_W(LANE_W)) u_lane (
      .src  (src[l*LANE_W +: LANE_W]),
      .shv  (shv[l*LANE_W +: LANE_W]),
      .arith(arith),
      .size (size),
      .res  (nxt[l*LANE_W +: LANE_W])
    );

    // R3: upper half of every lane reads zero
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (result[l*LANE_W + HALF +: HALF] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  p_vld_follows_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_vld_drops_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

// File: tb/rshn_unit_bench.sv
module rshn_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         arith = 1'b0;
  logic [1:0]   size = 2'd0;
  logic [255:0] src = '0;
  logic [255:0] shv = '0;
  logic         out_valid;
  logic [255:0] result;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rshn_unit u_rshn_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .arith(arith), .size(size),
    .src(src), .shv(shv), .out_valid(out_valid), .result(result)
  );

  // rounding reference: floor((x + 2^(s-1)) / 2^s) in wide signed arithmetic
  function automatic logic [255:0] model(logic [255:0] a, logic [255:0] k,
                                         logic ar, logic [1:0] sz);
    logic [255:0] r = '0;
    if (sz == 2'd3) return r;
    for (int l = 0; l < 2; l++) begin
      int w = 16 << sz;
      for (int j = 0; j < 128 / w; j++) begin
        logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
        logic [63:0] x = 64'(a >> (l*128 + j*w)) & mask;
        int s = int'(64'(k >> (l*128 + j*w)) & 64'(w - 1));
        logic signed [67:0] v = {4'b0, x};
        logic [255:0] q;
        if (ar && x[w-1]) v = v | ~{4'b0, mask};
        if (s != 0) v = (v + (68'sd1 <<< (s - 1))) >>> s;
        q = 256'(v[63:0] & (mask >> (w/2)));
        r = r | (q << (l*128 + j*(w/2)));
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [255:0] got, logic [255:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [255:0] a, logic [255:0] k, logic ar, logic [1:0] sz);
    @(negedge clk);
    src = a; shv = k; arith = ar; size = sz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // row: {size[1:0], arith, shift pattern[1:0]} ; pattern 0=zero 1=W-1 2=random 3=random with high bits
  localparam logic [4:0] TBL [18] = '{
    5'b00_0_00, 5'b00_0_01, 5'b00_1_01, 5'b00_1_10, 5'b00_0_11, 5'b00_1_00,
    5'b01_0_00, 5'b01_0_01, 5'b01_1_01, 5'b01_1_10, 5'b01_0_11, 5'b01_1_00,
    5'b10_0_00, 5'b10_0_01, 5'b10_1_01, 5'b10_1_10, 5'b10_0_11, 5'b10_1_00
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, k, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset result", result, '0);
    chk("R9 reset valid", {255'b0, out_valid}, '0);

    // R6 rounding: 3 >> 1 = 1, discarded bit 1 -> 2
    apply(256'h0003, 256'h0001, 1'b0, 2'd0);
    chk("R6 round up", result, 256'h02);
    chk("R8 out_valid", {255'b0, out_valid}, 256'd1);

    // R5 logical versus arithmetic: 0x8000 >> 12
    apply(256'h8000, 256'd12, 1'b0, 2'd0);
    chk("R5 logical", result, 256'h08);
    apply(256'h8000, 256'd12, 1'b1, 2'd0);
    chk("R5 arithmetic", result, 256'hF8);

    // R4 shift 17 on 16-bit element acts as 1
    apply(256'h0003, 256'h0011, 1'b0, 2'd0);
    chk("R4 modulo", result, 256'h02);

    // R7 reserved size code
    apply('1, 256'h1, 1'b0, 2'd3);
    chk("R7 code3 zero", result, '0);

    // R2 element 1 of 32-bit form lands at bits [31:16]
    apply(256'h0003_0000_0000_0000, 256'h0010_0000_0000, 1'b0, 2'd1);
    chk("R2 packing", result, 256'h0003_0000);

    // R6 truncation without saturation: all-ones >> 1 rounds to 2^63 -> low 32 zero
    apply({192'b0, 64'hFFFF_FFFF_FFFF_FFFF}, 256'd1, 1'b0, 2'd2);
    chk("R6 wrap", result, '0);
    apply({192'b0, 64'hFFFF_FFFF_FFFF_FFFF}, 256'd0, 1'b0, 2'd2);
    chk("R6 zero shift", result, 256'hFFFF_FFFF);

    // R3 all-ones source still leaves upper lane halves zero
    apply('1, '0, 1'b0, 2'd0);
    chk("R3 hi zero", result, {64'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'b0, 64'hFFFF_FFFF_FFFF_FFFF});

    // R1 lane isolation: lane1 value 0x10 >> 4 = 1, lane0 random data ignored by lane1
    a = rnd256(); a[255:128] = 128'h10;
    k = rnd256(); k[255:128] = 128'h4;
    apply(a, k, 1'b1, 2'd2);
    chk("R1 lane1", {128'b0, result[255:128]}, 256'h1);
    a[127:0] = ~a[127:0];
    apply(a, k, 1'b1, 2'd2);
    chk("R1 lane1 after lane0 change", {128'b0, result[255:128]}, 256'h1);

    // R8 hold when strobe is low
    prev = result;
    @(negedge clk);
    src = rnd256(); shv = rnd256();
    @(negedge clk);
    chk("R8 hold", result, prev);
    chk("R8 valid low", {255'b0, out_valid}, '0);

    // table walk against the reference model
    foreach (TBL[i]) begin
      logic [1:0] sz = TBL[i][4:3];
      logic ar = TBL[i][2];
      int w = 16 << sz;
      a = rnd256();
      k = '0;
      for (int e = 0; e < 256 / w; e++) begin
        logic [255:0] f;
        case (TBL[i][1:0])
          2'd0: f = '0;
          2'd1: f = 256'(w - 1);
          2'd2: f = 256'($urandom_range(0, w - 1));
          default: f = 256'($urandom) | 256'(w);
        endcase
        k = k | ((f & ((256'd1 << w) - 1)) << (e * w));
      end
      apply(a, k, ar, sz);
      chk($sformatf("R2 R4 R5 R6 R7 row %0d", i), result, model(a, k, ar, sz));
    end

    // R9 reset again clears the register
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 re-reset", result, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule